// File: doc/BRIEF.md
# Stream Packetizer with Tag Header

This block takes a continuous stream of 16-bit samples and cuts it into packets for a processing ring. It gathers a chunk of samples into an internal buffer. When the chunk is complete, or when the flush input closes a partial chunk, it sends a self-describing header followed by the buffered samples. The header gives, in a fixed order, the total packet length, an ordered list of operation tags, a reserved delimiter word that ends that list, and the number of data words.

The tag values sit in a small register set that is written through a simple write port before streaming starts. The chunk size and the number of tags are configuration inputs. They are captured when the first sample of each packet is accepted. Both the input and the output are valid/ready word streams. The output flags the final data word of every packet. While a packet is being sent the input is held off, so no sample is dropped or repeated under backpressure.

Top module: `stream_packetizer`

## Requirements
- R1: After reset is released, out_valid is 0 and in_ready is 1, and no word is sent until samples have been accepted.
- R2: A packet of T tags and D data words is sent as: one length word equal to 3+T+D, then T tag words, then the delimiter 0xFFFF, then one word equal to D, then the D samples in the order they were accepted.
- R3: The chunk size C is taken from cfg_chunk in the cycle that accepts the first sample of a packet. A value of 0 counts as 1, and a value above 32 counts as 32. The packet closes in the cycle that accepts its C-th sample.
- R4: The tag count T is taken from cfg_tags in the same cycle as C, and a value above 8 counts as 8. With T=0 the delimiter follows the length word directly.
- R5: While the buffer holds at least one sample (counting a sample accepted in the same cycle), a high flush closes the packet with D equal to the samples held. Flush with an empty buffer has no effect and produces no output.
- R6: in_ready is low from the cycle after a packet closes until the handshake of its last word, and every accepted sample appears exactly once.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R8: out_last is high on exactly the final data word of each packet, and on no other word.
- R9: Tag register i (i = 0..7) is written with tag_wr_data when tag_wr_en is high and tag_wr_idx equals i. Tag word k of a header is the content of register k. The value 0xFFFF is never written as a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_chunk | input | 6 | Requested samples per packet |
| cfg_tags | input | 4 | Requested number of tags per header |
| tag_wr_en | input | 1 | Tag register write strobe |
| tag_wr_idx | input | 3 | Tag register index |
| tag_wr_data | input | 16 | Tag value to write |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Input sample |
| flush | input | 1 | Close the current partial chunk |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 16 | Header or data word |
| out_last | output | 1 | Final word of the packet |

## Verification
The assertions rely on three things about the inputs:
- The tag registers are never written with the delimiter value.
- The tag registers are not rewritten while a header is being sent, so a stalled tag word stays stable.
- The reset is applied before any traffic.

The stimulus writes the tag registers only while the block is idle and empty, and only with values in a range far from 0xFFFF. It raises valid, flush and ready in both fixed and pseudo-random patterns, and it changes the configuration only between packets or while the fill is in progress, so that the capture rule is exercised.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  typedef enum logic [2:0] {
    ST_FILL  = 3'd0,
    ST_LEN   = 3'd1,
    ST_TAG   = 3'd2,
    ST_DELIM = 3'd3,
    ST_DLEN  = 3'd4,
    ST_DATA  = 3'd5
  } pkt_state_e;
endpackage

// File: rtl/pkt_tag_regs.sv
module pkt_tag_regs #(
  parameter int W  = 16,
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic en;
    assign en = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= '0;
      else if (en) regs[g] <= wr_data;
    end
  end

  assign rd_data = regs[rd_idx];

  // R9: the delimiter value is reserved and never stored as a tag
  assert_tag_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data != {W{1'b1}}));
endmodule

// File: rtl/pkt_chunk_mem.sv
module pkt_chunk_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_pkg::*;
#(
  parameter int W         = 16,
  parameter int MAX_CHUNK = 32,
  parameter int MAX_TAGS  = 8,
  parameter int CW        = $clog2(MAX_CHUNK + 1),
  parameter int TW        = $clog2(MAX_TAGS + 1),
  parameter int AW        = $clog2(MAX_CHUNK),
  parameter int TIW       = $clog2(MAX_TAGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cfg_chunk,
  input  logic [TW-1:0]  cfg_tags,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           flush,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data,
  output logic           out_last,
  output logic           mem_we,
  output logic [AW-1:0]  mem_waddr,
  output logic [AW-1:0]  mem_raddr,
  input  logic [W-1:0]   mem_rdata,
  output logic [TIW-1:0] tag_idx,
  input  logic [W-1:0]   tag_data
);
  localparam int IW = (CW > TW) ? CW : TW;
  localparam logic [W-1:0] DELIM = {W{1'b1}};

  pkt_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lchunk_q, lchunk_d;
  logic [TW-1:0] ltags_q, ltags_d;
  logic [IW-1:0] idx_q, idx_d;

  logic          accept, fire, close, last_word;
  logic [CW-1:0] cnt_inc, chunk_cl, eff_chunk;
  logic [TW-1:0] tags_cl;

  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = (state_q != ST_FILL);
  assign accept    = in_ready && in_valid;
  assign fire      = out_valid && out_ready;
  assign cnt_inc   = cnt_q + {{(CW-1){1'b0}}, accept};

  assign chunk_cl  = (cfg_chunk == '0) ? CW'(1) :
                     ((cfg_chunk > CW'(MAX_CHUNK)) ? CW'(MAX_CHUNK) : cfg_chunk);
  assign tags_cl   = (cfg_tags > TW'(MAX_TAGS)) ? TW'(MAX_TAGS) : cfg_tags;
  assign eff_chunk = (cnt_q == '0) ? chunk_cl : lchunk_q;

  assign close     = in_ready && ((accept && (cnt_inc == eff_chunk)) ||
                                  (flush && (cnt_inc != '0)));
  assign last_word = (state_q == ST_DATA) && (idx_q == IW'(cnt_q) - IW'(1));

  assign mem_we    = accept;
  assign mem_waddr = cnt_q[AW-1:0];
  assign mem_raddr = idx_q[AW-1:0];
  assign tag_idx   = idx_q[TIW-1:0];
  assign out_last  = last_word;

  always_comb begin
    case (state_q)
      ST_LEN:   out_data = W'(3) + W'(ltags_q) + W'(cnt_q);
      ST_TAG:   out_data = tag_data;
      ST_DELIM: out_data = DELIM;
      ST_DLEN:  out_data = W'(cnt_q);
      ST_DATA:  out_data = mem_rdata;
      default:  out_data = '0;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    lchunk_d = lchunk_q;
    ltags_d  = ltags_q;
    case (state_q)
      ST_FILL: begin
        if (accept) begin
          cnt_d = cnt_inc;
          if (cnt_q == '0) begin
            lchunk_d = chunk_cl;
            ltags_d  = tags_cl;
          end
        end
        if (close) begin
          state_d = ST_LEN;
          idx_d   = '0;
        end
      end
      ST_LEN: if (fire) state_d = (ltags_q == '0) ? ST_DELIM : ST_TAG;
      ST_TAG: if (fire) begin
        if (idx_q == IW'(ltags_q) - IW'(1)) begin
          state_d = ST_DELIM;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      ST_DELIM: if (fire) state_d = ST_DLEN;
      ST_DLEN: if (fire) begin
        state_d = ST_DATA;
        idx_d   = '0;
      end
      ST_DATA: if (fire) begin
        if (last_word) begin
          state_d = ST_FILL;
          cnt_d   = '0;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      default: state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_FILL;
      cnt_q    <= '0;
      idx_q    <= '0;
      lchunk_q <= '0;
      ltags_q  <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      lchunk_q <= lchunk_d;
      ltags_q  <= ltags_d;
    end
  end

  // R3: a sent packet never holds more samples than its captured chunk size
  assert_chunk_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FILL) |-> (cnt_q <= lchunk_q));

  // R5: no packet is ever sent without data
  assert_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_q != '0));

  // R6: the buffered sample count is frozen while a packet is being sent
  assert_count_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(fire && out_last)) |=> (cnt_q == $past(cnt_q)));

  // R7: a stalled word is held
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: after the last word is taken the block returns to accepting input
  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> (!out_valid && in_ready));
endmodule

// File: rtl/stream_packetizer.sv
module stream_packetizer #(
  parameter int W         = 16,
  parameter int MAX_CHUNK = 32,
  parameter int MAX_TAGS  = 8,
  parameter int CW        = $clog2(MAX_CHUNK + 1),
  parameter int TW        = $clog2(MAX_TAGS + 1),
  parameter int TIW       = $clog2(MAX_TAGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cfg_chunk,
  input  logic [TW-1:0]  cfg_tags,
  input  logic           tag_wr_en,
  input  logic [TIW-1:0] tag_wr_idx,
  input  logic [W-1:0]   tag_wr_data,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  input  logic           flush,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data,
  output logic           out_last
);
  localparam int AW = $clog2(MAX_CHUNK);

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           mem_we;
  logic [AW-1:0]  mem_waddr, mem_raddr;
  logic [W-1:0]   mem_rdata, tag_data;
  logic [TIW-1:0] tag_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pkt_tag_regs #(.W(W), .N(MAX_TAGS), .IW(TIW)) u_tags (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(tag_wr_en), .wr_idx(tag_wr_idx), .wr_data(tag_wr_data),
    .rd_idx(tag_idx), .rd_data(tag_data)
  );

  pkt_chunk_mem #(.W(W), .DEPTH(MAX_CHUNK), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(in_data),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  pkt_seq #(
    .W(W), .MAX_CHUNK(MAX_CHUNK), .MAX_TAGS(MAX_TAGS),
    .CW(CW), .TW(TW), .AW(AW), .TIW(TIW)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_chunk(cfg_chunk), .cfg_tags(cfg_tags),
    .in_valid(in_valid), .in_ready(in_ready), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .tag_idx(tag_idx), .tag_data(tag_data)
  );
endmodule

// File: tb/tb_stream_packetizer.sv
module tb_stream_packetizer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cfg_chunk;
  logic [3:0]  cfg_tags;
  logic        tag_wr_en;
  logic [2:0]  tag_wr_idx;
  logic [15:0] tag_wr_data;
  logic        in_valid, in_ready, flush;
  logic [15:0] in_data;
  logic        out_valid, out_ready, out_last;
  logic [15:0] out_data;

  always #2 clk = ~clk;

  stream_packetizer dut (
    .clk(clk), .rst_n(rst_n), .cfg_chunk(cfg_chunk), .cfg_tags(cfg_tags),
    .tag_wr_en(tag_wr_en), .tag_wr_idx(tag_wr_idx), .tag_wr_data(tag_wr_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  typedef struct {
    logic [15:0] d;
    bit          last;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] fillq[$];
  logic [15:0] tagm[8];
  int          mc, mt;
  bit          filling;
  logic [15:0] samp;
  int          checks, errors;
  string       cur_req;

  function automatic int clamp_chunk(int v);
    return (v == 0) ? 1 : ((v > 32) ? 32 : v);
  endfunction

  function automatic int clamp_tags(int v);
    return (v > 8) ? 8 : v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic build_packet();
    int d = fillq.size();
    exp_t e;
    e.last = 0;
    e.d = 16'(3 + mt + d);   expq.push_back(e);
    for (int k = 0; k < mt; k++) begin e.d = tagm[k]; expq.push_back(e); end
    e.d = 16'hFFFF;          expq.push_back(e);
    e.d = 16'(d);            expq.push_back(e);
    for (int k = 0; k < d; k++) begin
      e.d = fillq[k];
      e.last = (k == d - 1);
      expq.push_back(e);
    end
    fillq.delete();
  endtask

  // called just after a falling edge: compare, drive, advance model
  task automatic cycle(bit v, bit fl, bit rdy);
    check(in_ready == filling, "R6", "in_ready", int'(in_ready), int'(filling));
    check(out_valid == !filling, cur_req, "out_valid", int'(out_valid), int'(!filling));
    if (!filling && out_valid && expq.size() > 0) begin
      check(out_data == expq[0].d, cur_req, "out_data", int'(out_data), int'(expq[0].d));
      check(out_last == expq[0].last, "R8", "out_last", int'(out_last), int'(expq[0].last));
    end else if (!out_valid) begin
      check(out_last == 1'b0, "R8", "out_last idle", int'(out_last), 0);
    end
    in_valid  = v;
    in_data   = samp;
    flush     = fl;
    out_ready = rdy;
    if (filling) begin
      if (v) begin
        if (fillq.size() == 0) begin
          mc = clamp_chunk(int'(cfg_chunk));
          mt = clamp_tags(int'(cfg_tags));
        end
        fillq.push_back(samp);
        samp++;
      end
      if ((v && fillq.size() == mc) || (fl && fillq.size() > 0)) begin
        build_packet();
        filling = 0;
      end
    end else if (rdy) begin
      void'(expq.pop_front());
      if (expq.size() == 0) filling = 1;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && !filling; i++) cycle(0, 0, 1);
  endtask

  task automatic wr_tag(int idx, logic [15:0] val);
    tag_wr_en = 1; tag_wr_idx = 3'(idx); tag_wr_data = val;
    tagm[idx] = val;
    @(negedge clk);
    tag_wr_en = 0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    checks = 0; errors = 0; filling = 1; samp = 16'h1000; mc = 1; mt = 0;
    cur_req = "R1";
    rst_n = 0; cfg_chunk = 4; cfg_tags = 3;
    tag_wr_en = 0; tag_wr_idx = 0; tag_wr_data = 0;
    in_valid = 0; in_data = 0; flush = 0; out_ready = 0;
    for (int k = 0; k < 8; k++) tagm[k] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);
    for (int i = 0; i < 4; i++) cycle(0, 0, 1);

    cur_req = "R9";
    for (int k = 0; k < 8; k++) wr_tag(k, 16'(16'h0A00 + k * 3));
    for (int i = 0; i < 3; i++) cycle(0, 0, 1);

    cur_req = "R2"; cfg_chunk = 4; cfg_tags = 3;
    for (int i = 0; i < 40; i++) cycle(1, 0, 1);
    drain();

    cur_req = "R4"; cfg_chunk = 3; cfg_tags = 0;
    for (int i = 0; i < 30; i++) cycle(1, 0, 1);
    drain();
    cfg_chunk = 2; cfg_tags = 12;
    for (int i = 0; i < 60; i++) cycle(1, 0, 1);
    drain();

    cur_req = "R3"; cfg_chunk = 0; cfg_tags = 1;
    for (int i = 0; i < 30; i++) cycle(1, 0, 1);
    drain();
    cfg_chunk = 45; cfg_tags = 2;
    for (int i = 0; i < 120; i++) cycle(1, 0, 1);
    drain();

    cur_req = "R5"; cfg_chunk = 10; cfg_tags = 2;
    for (int i = 0; i < 4; i++) cycle(1, 0, 1);
    cycle(0, 1, 1);
    drain();
    for (int i = 0; i < 5; i++) cycle(0, 1, 1);
    cycle(1, 1, 1);
    drain();
    check(fillq.size() == 0 && filling, "R5", "model idle after flush", fillq.size(), 0);

    cur_req = "R7"; cfg_chunk = 5; cfg_tags = 2;
    for (int i = 0; i < 3000; i++)
      cycle(1'($urandom % 2), ($urandom % 17) == 0, ($urandom % 3) != 0);
    cur_req = "R6";
    for (int i = 0; i < 20; i++) cycle(0, 1, 1);
    drain();

    report();
    $finish;
  end
endmodule